// File: doc/BRIEF.md
# Write Suspend/Resume Controller

This block sequences a self-timed write engine that erases and programs non-volatile storage. Decoded command strobes enter on a single cycle each: a start strobe with an operation kind and a target address, a suspend strobe and a resume strobe. The block runs an internal countdown for the active operation and shows it through `busy_o`. When the countdown runs out it gives a one-cycle `done_o` pulse.

Sector erase, block erase and page program can be parked in one suspension slot. The slot keeps the operation kind, its address and the remaining time. While an operation is parked, `busy_o` is low, so another operation may run to completion. A later resume reloads the parked time and carries on from that point. Chip erase can never be parked, and it cannot start while anything is parked. Every strobe gets a one-cycle verdict on `accept_o` or `reject_o`.

Top module: `wsr_ctrl`

## Requirements
- R1: After reset `busy_o`, `done_o`, `susp_o`, `accept_o` and `reject_o` are all low.
- R2: A start accepted while idle raises `busy_o` at the next edge and holds it for exactly the duration of its kind. The defaults are 16 cycles for sector erase (op 0), 24 for block erase (op 1), 8 for page program (op 2) and 32 for chip erase (op 3). `busy_o` falls together with a single-cycle `done_o` pulse.
- R3: A start strobe while `busy_o` is high is rejected and leaves the running operation's timing unchanged.
- R4: A suspend during a running sector erase, block erase or page program, with nothing parked, does three things at the next edge: it clears `busy_o`, sets `susp_o`, and shows the parked kind on `susp_op_o` in the op encoding. No `done_o` pulse follows.
- R5: A suspend during chip erase is ignored, and the chip erase completes on its original schedule.
- R6: A suspend while an operation is already parked is ignored, and the operation currently running continues.
- R7: A chip-erase start is rejected while `susp_o` is high.
- R8: A resume while idle with an operation parked clears `susp_o` and raises `busy_o` for exactly the cycles that remained at the suspend, however long it stayed parked.
- R9: A resume with nothing parked, or while `busy_o` is high, is ignored.
- R10: A start of the same kind as the parked operation is rejected when its address falls in the same region. The region is set by the address bits from bit 12 up for sector erase, from bit 16 up for block erase, and from bit 8 up for page program. A different region or a different kind is accepted.
- R11: Each cycle carrying a strobe gives, at the next edge, one cycle of `accept_o` if an action was taken, or otherwise `reject_o`. If several strobes arrive together, suspend outranks resume, resume outranks start, and only the highest one is considered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe |
| op_i | input | 2 | Kind for start: 0 sector, 1 block, 2 page, 3 chip |
| addr_i | input | ADDR_W | Target address for start |
| suspend_i | input | 1 | Suspend strobe |
| resume_i | input | 1 | Resume strobe |
| busy_o | output | 1 | An operation is running |
| done_o | output | 1 | One-cycle completion pulse |
| susp_o | output | 1 | An operation is parked |
| susp_op_o | output | 2 | Kind of the parked operation |
| accept_o | output | 1 | The previous cycle's strobe was acted on |
| reject_o | output | 1 | The previous cycle's strobe was refused |

## Verification
Every result is registered once, so the effect of a strobe sampled at one edge appears on all outputs immediately after that edge. This covers the verdict, the `busy_o` change, the parked flag and kind, and a completion pulse. The bench changes inputs 1 ns after a rising edge and compares outputs 1 ns after the following edge, against a cycle model advanced once per edge. Run lengths are counted in whole cycles from the edge that accepted the start or resume.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  typedef enum logic [1:0] {
    OP_SECT = 2'd0,
    OP_BLK  = 2'd1,
    OP_PAGE = 2'd2,
    OP_CHIP = 2'd3
  } op_e;
endpackage

// File: rtl/wsr_timer.sv
module wsr_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             halt_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        busy_o <= 1'b1;
        cnt_o  <= load_val_i;
      end else if (halt_i) begin
        busy_o <= 1'b0;
      end else if (busy_o) begin
        if (cnt_o == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o - CNT_W'(1);
        end
      end
    end
  end

  assert_count_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cnt_o > CNT_W'(1) && !load_i && !halt_i |=> busy_o && cnt_o == $past(cnt_o) - CNT_W'(1));
  assert_halt_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i && !load_i |=> !busy_o && !done_o);
  assert_load_value_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o && cnt_o == $past(load_val_i));
endmodule

// File: rtl/wsr_slot.sv
module wsr_slot
  import wsr_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              save_i,
  input  logic              restore_i,
  input  op_e               op_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              valid_o,
  output op_e               op_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      op_o    <= OP_SECT;
      cnt_o   <= '0;
      addr_o  <= '0;
    end else if (save_i) begin
      valid_o <= 1'b1;
      op_o    <= op_i;
      cnt_o   <= cnt_i;
      addr_o  <= addr_i;
    end else if (restore_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_single_slot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_i |-> !valid_o);
  assert_restore_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |-> valid_o);
  assert_frozen_time_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !restore_i |=> valid_o && $stable(cnt_o) && $stable(op_o));
endmodule

// File: rtl/wsr_arbiter.sv
module wsr_arbiter
  import wsr_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int SECT_SH = 12,
  parameter int BLK_SH  = 16,
  parameter int PAGE_SH = 8
) (
  input  logic              start_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  input  op_e               run_op_i,
  input  logic              parked_i,
  input  op_e               park_op_i,
  input  logic [ADDR_W-1:0] park_addr_i,
  output logic              do_start_o,
  output logic              do_suspend_o,
  output logic              do_resume_o
);
  function automatic logic same_region(op_e k, logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] b);
    int unsigned sh;
    case (k)
      OP_SECT: sh = SECT_SH;
      OP_BLK:  sh = BLK_SH;
      default: sh = PAGE_SH;
    endcase
    return (a >> sh) == (b >> sh);
  endfunction

  logic blocked;

  always_comb begin
    blocked = parked_i && (op_i == OP_CHIP ||
              (op_i == park_op_i && same_region(op_i, addr_i, park_addr_i)));
    do_suspend_o = suspend_i && busy_i && run_op_i != OP_CHIP && !parked_i;
    do_resume_o  = !suspend_i && resume_i && !busy_i && parked_i;
    do_start_o   = !suspend_i && !resume_i && start_i && !busy_i && !blocked;
  end
endmodule

// File: rtl/wsr_ctrl.sv
module wsr_ctrl
  import wsr_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int T_SECT  = 16,
  parameter int T_BLK   = 24,
  parameter int T_PAGE  = 8,
  parameter int T_CHIP  = 32,
  parameter int SECT_SH = 12,
  parameter int BLK_SH  = 16,
  parameter int PAGE_SH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              susp_o,
  output logic [1:0]        susp_op_o,
  output logic              accept_o,
  output logic              reject_o
);
  localparam int T_MAX0 = (T_SECT > T_BLK) ? T_SECT : T_BLK;
  localparam int T_MAX1 = (T_PAGE > T_CHIP) ? T_PAGE : T_CHIP;
  localparam int T_MAX  = (T_MAX0 > T_MAX1) ? T_MAX0 : T_MAX1;
  localparam int CNT_W  = $clog2(T_MAX + 1);

  op_e               op_in, run_op_q, park_op;
  logic [ADDR_W-1:0] run_addr_q, park_addr;
  logic [CNT_W-1:0]  cnt, park_cnt, load_val, dur;
  logic              do_start, do_suspend, do_resume, parked;

  assign op_in = op_e'(op_i);

  always_comb begin
    case (op_in)
      OP_SECT: dur = CNT_W'(T_SECT);
      OP_BLK:  dur = CNT_W'(T_BLK);
      OP_PAGE: dur = CNT_W'(T_PAGE);
      default: dur = CNT_W'(T_CHIP);
    endcase
    load_val = do_resume ? park_cnt : dur;
  end

  wsr_arbiter #(.ADDR_W(ADDR_W), .SECT_SH(SECT_SH), .BLK_SH(BLK_SH), .PAGE_SH(PAGE_SH)) u_arb (
    .start_i(start_i), .suspend_i(suspend_i), .resume_i(resume_i),
    .op_i(op_in), .addr_i(addr_i), .busy_i(busy_o), .run_op_i(run_op_q),
    .parked_i(parked), .park_op_i(park_op), .park_addr_i(park_addr),
    .do_start_o(do_start), .do_suspend_o(do_suspend), .do_resume_o(do_resume)
  );

  wsr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(do_start | do_resume),
    .load_val_i(load_val), .halt_i(do_suspend),
    .busy_o(busy_o), .cnt_o(cnt), .done_o(done_o)
  );

  wsr_slot #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_slot (
    .clk_i(clk_i), .rst_ni(rst_ni), .save_i(do_suspend), .restore_i(do_resume),
    .op_i(run_op_q), .cnt_i(cnt), .addr_i(run_addr_q),
    .valid_o(parked), .op_o(park_op), .cnt_o(park_cnt), .addr_o(park_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_op_q   <= OP_SECT;
      run_addr_q <= '0;
      accept_o   <= 1'b0;
      reject_o   <= 1'b0;
    end else begin
      if (do_start) begin
        run_op_q   <= op_in;
        run_addr_q <= addr_i;
      end else if (do_resume) begin
        run_op_q   <= park_op;
        run_addr_q <= park_addr;
      end
      accept_o <= do_start | do_suspend | do_resume;
      reject_o <= (start_i | suspend_i | resume_i) & ~(do_start | do_suspend | do_resume);
    end
  end

  assign susp_o    = parked;
  assign susp_op_o = park_op;

  assert_one_action_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({do_start, do_suspend, do_resume}));
  assert_verdict_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && reject_o));
  assert_suspend_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_suspend |=> !busy_o && susp_o && susp_op_o == $past(run_op_q));
  assert_chip_never_parked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && run_op_q == OP_CHIP |-> !susp_o);
  assert_chip_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_o |-> susp_op_o != OP_CHIP);
  assert_idle_resume_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_i && !susp_o && !busy_o && !start_i && !suspend_i |=> !busy_o);
  assert_done_ends_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
endmodule

// File: tb/wsr_ctrl_bench.sv
`timescale 1ns/1ps
module wsr_ctrl_bench;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, susp = 1'b0, res = 1'b0;
  logic [1:0]    op = 2'd0;
  logic [AW-1:0] addr = '0;
  logic          busy, done, parked, acc, rej;
  logic [1:0]    park_op;

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  // reference state
  logic          m_busy = 0, m_done = 0, m_sv = 0, m_acc = 0, m_rej = 0;
  logic [1:0]    m_op = 0, m_sop = 0;
  int            m_cnt = 0, m_scnt = 0;
  logic [AW-1:0] m_addr = '0, m_saddr = '0;

  always #2 clk = ~clk;

  wsr_ctrl u_wsr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .addr_i(addr),
    .suspend_i(susp), .resume_i(res), .busy_o(busy), .done_o(done),
    .susp_o(parked), .susp_op_o(park_op), .accept_o(acc), .reject_o(rej)
  );

  function automatic int dur(logic [1:0] k);
    case (k)
      2'd0: return 16;
      2'd1: return 24;
      2'd2: return 8;
      default: return 32;
    endcase
  endfunction

  function automatic bit region_hit(logic [1:0] k, logic [AW-1:0] a, logic [AW-1:0] b);
    int sh = (k == 2'd0) ? 12 : (k == 2'd1) ? 16 : 8;
    return (a >> sh) == (b >> sh);
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_next();
    bit ok = 0, any = start | susp | res;
    m_done = 0;
    if (susp)      ok = m_busy && m_op != 2'd3 && !m_sv;
    else if (res)  ok = !m_busy && m_sv;
    else if (start) ok = !m_busy && !(m_sv && (op == 2'd3 || (op == m_sop && region_hit(op, addr, m_saddr))));
    if (ok && susp) begin
      m_sv = 1; m_sop = m_op; m_scnt = m_cnt; m_saddr = m_addr; m_busy = 0;
    end else if (ok && res) begin
      m_busy = 1; m_cnt = m_scnt; m_op = m_sop; m_addr = m_saddr; m_sv = 0;
    end else if (ok && start) begin
      m_busy = 1; m_cnt = dur(op); m_op = op; m_addr = addr;
    end else if (m_busy) begin
      if (m_cnt == 1) begin m_busy = 0; m_done = 1; end
      else m_cnt--;
    end
    m_acc = any && ok;
    m_rej = any && !ok;
  endtask

  task automatic compare_all();
    chk("busy", busy, m_busy);
    chk("done", done, m_done);
    chk("susp", parked, m_sv);
    if (m_sv) chk("susp_op", park_op, m_sop);
    chk("accept", acc, m_acc);
    chk("reject", rej, m_rej);
  endtask

  task automatic step();
    model_next();
    @(posedge clk); #1;
    start = 0; susp = 0; res = 0;
    compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_start(logic [1:0] k, logic [AW-1:0] a);
    start = 1; op = k; addr = a; step();
  endtask
  task automatic do_susp(); susp = 1; step(); endtask
  task automatic do_res();  res = 1;  step(); endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tag = "R1"; compare_all();

    tag = "R2";
    for (int k = 0; k < 4; k++) begin
      do_start(2'(k), 24'h000100);
      idle(dur(2'(k)) + 2);
    end
    chk("idle after runs", busy, 0);

    tag = "R3";
    do_start(2'd0, 24'h001000); idle(3);
    do_start(2'd1, 24'h020000); chk("rejected start", rej, 1);
    idle(15);

    tag = "R4";
    do_start(2'd0, 24'h003000); idle(5);
    do_susp(); chk("busy dropped", busy, 0); chk("parked kind", park_op, 0);
    tag = "R8";
    idle(9); do_res(); chk("resumed", busy, 1);
    idle(12);

    tag = "R5";
    do_start(2'd3, 24'h0); idle(4); do_susp();
    chk("chip keeps running", busy, 1); chk("nothing parked", parked, 0);
    idle(30);

    tag = "R10";
    do_start(2'd0, 24'h001000); idle(2); do_susp();
    do_start(2'd0, 24'h0010AB); chk("same region", rej, 1);
    do_start(2'd0, 24'h002000); chk("other region", acc, 1);
    tag = "R6";
    idle(2); do_susp(); chk("second suspend ignored", busy, 1);
    idle(16);
    tag = "R10";
    do_start(2'd2, 24'h001000); chk("other kind", acc, 1);
    idle(9);
    tag = "R7";
    do_start(2'd3, 24'h0); chk("chip refused", busy, 0);
    tag = "R9";
    do_start(2'd2, 24'h000400); do_res(); chk("resume while busy", rej, 1);
    idle(9);
    tag = "R8";
    do_res(); idle(16);
    tag = "R9";
    do_res(); chk("resume nothing", busy, 0);

    tag = "R11";
    do_start(2'd1, 24'h040000); idle(2);
    susp = 1; start = 1; op = 2'd2; addr = 24'h0; step();
    chk("suspend wins", parked, 1);
    res = 1; start = 1; op = 2'd2; step();
    chk("resume wins", busy, 1);
    idle(30);

    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom % 16);
      op = 2'($urandom % 4);
      addr = AW'((($urandom % 4) << 12) | (($urandom % 2) << 16) | ($urandom % 256));
      if (r < 2) start = 1;
      else if (r == 2) susp = 1;
      else if (r == 3) res = 1;
      else if (r == 4) begin start = 1; susp = 1; end
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule